// File: doc/BRIEF.md
# Vector Branch Length Truncation Unit

This unit runs the per-element loop of a vectorised conditional branch. After a start pulse it captures a vector of condition bits, a predicate mask, the requested vector length, a maximum length, a loop counter and the mode controls. It then walks the elements in ascending order, one element per clock. Bit i of each vector belongs to element i.

Elements whose predicate bit is 0 are not tested. A tested element can decrement the loop counter in counter-test mode. When length truncation is enabled, the walk stops at the first tested element whose outcome matches the truncation criterion. The new vector length is then derived from that stop point in one of three ways, chosen by the inclusive bit and the zeroing bit:

- the stop element is included;
- the stop index itself is used, so masked elements are counted;
- one plus the index of the last tested element is used, so masked elements are not counted.

Results are presented together with a one-cycle done pulse. They hold until the next start.

Top module: `vbr_trunc_unit`

## Requirements
- R1: Elements are processed in ascending order, one per clock. The first element is processed on the edge after the edge that captures start_i. done_o is registered on the edge that processes the terminating element. That is, done_o rises T+1 edges after the capture edge, where T is the terminating index (T=0 when the effective length is 0).
- R2: A tested element with outcome s (its condition bit) meets the truncation criterion when vlset_i=1 and s equals vsb_i. With vsb_i=1 this means the branch would proceed; with vsb_i=0 it means the branch would not take place.
- R3: With vli_i=1, a criterion hit at index i sets vl_o=i+1 whatever sz_i is. That element still applies its counter decrement and its branch decision.
- R4: With vli_i=0 and sz_i=0, a hit at index i sets vl_o to one plus the index of the last tested element before i, or to 0 if no element was tested before i.
- R5: With vli_i=0 and sz_i=1, a hit at index i sets vl_o=i, so masked-out elements count toward the length.
- R6: With vli_i=0, the hitting element makes no counter decrement and no branch decision, and the walk ends on it.
- R7: The effective length is min(vl_i, mvl_i, MAX_VL). If no element hits, or vlset_i=0, then vl_o equals the effective length. An effective length of 0 finishes with vl_o=0. The maximum length is only read, never written.
- R8: With ctr_test_i=1, every tested element whose condition bit differs from cti_i decrements the counter by one, modulo 2^CTR_W. With ctr_test_i=0 the counter passes through unchanged. ctr_o is final from done_o onward.
- R9: An element whose predicate bit is 0 is skipped: no counter change, no hit, no branch decision.
- R10: taken_o is the condition bit of the last element that made a branch decision, or 0 if none did. lr_we_o pulses together with done_o only when taken_o=1 and link_i=1.
- R11: done_o is a single-cycle pulse. vl_o and taken_o hold after it. A start_i seen while a walk is running is ignored.
- R12: After reset, vl_o, ctr_o, taken_o, lr_we_o and done_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a walk when idle |
| cond_i | input | MAX_VL | Per-element branch condition outcome |
| pred_i | input | MAX_VL | Predicate mask, 1 = element tested |
| vl_i | input | VL_W | Current vector length |
| mvl_i | input | VL_W | Maximum vector length (read only) |
| ctr_i | input | CTR_W | Loop counter before the walk |
| vlset_i | input | 1 | Enables length truncation |
| vsb_i | input | 1 | Selects truncation on proceed (1) or on not-taken (0) |
| vli_i | input | 1 | Inclusive truncation |
| sz_i | input | 1 | Masked elements count toward the length |
| ctr_test_i | input | 1 | Enables per-element counter decrement |
| cti_i | input | 1 | Inverts the decrement condition |
| link_i | input | 1 | Branch writes the link register |
| vl_o | output | VL_W | New vector length |
| ctr_o | output | CTR_W | New loop counter |
| taken_o | output | 1 | Branch decision |
| lr_we_o | output | 1 | Link register write enable, pulsed with done |
| done_o | output | 1 | Walk finished, one-cycle pulse |

## Verification
Several properties are checked every cycle:
- done_o is a single pulse;
- a link write never occurs without a taken branch;
- the final length never exceeds the effective length;
- the counter moves by at most one per walk cycle and never on a masked element;
- a start during a walk leaves the captured length alone.

The exact truncation point is shown only by the bench's sweeps over every condition and mask pattern under each inclusive, inversion and zeroing combination, all checked against an arithmetic model. The same holds for the counter totals, the terminating latency and the length clamp.

// File: rtl/vbt_pkg.sv
package vbt_pkg;
  typedef struct packed {
    logic vlset;
    logic vsb;
    logic vli;
    logic sz;
    logic ctr_test;
    logic cti;
    logic link;
  } vbt_mode_t;

  typedef enum logic {ST_IDLE, ST_RUN} vbt_state_e;
endpackage

// File: rtl/vbt_elem_eval.sv
module vbt_elem_eval
  import vbt_pkg::*;
(
  input  logic      cond_bit_i,
  input  logic      pred_bit_i,
  input  vbt_mode_t mode_i,
  output logic      active_o,
  output logic      succ_o,
  output logic      hit_o,
  output logic      dec_o
);
  always_comb begin
    active_o = pred_bit_i;
    succ_o   = cond_bit_i;
    hit_o    = pred_bit_i & mode_i.vlset & (cond_bit_i == mode_i.vsb);
    dec_o    = pred_bit_i & mode_i.ctr_test & (cond_bit_i ^ mode_i.cti);
  end
endmodule

// File: rtl/vbt_len_calc.sv
module vbt_len_calc #(
  parameter int VL_W = 4
) (
  input  logic [VL_W-1:0] idx_i,
  input  logic [VL_W-1:0] last_idx_i,
  input  logic            last_v_i,
  input  logic            vli_i,
  input  logic            sz_i,
  output logic [VL_W-1:0] trunc_o
);
  always_comb begin
    if (vli_i)          trunc_o = idx_i + VL_W'(1);
    else if (sz_i)      trunc_o = idx_i;
    else if (last_v_i)  trunc_o = last_idx_i + VL_W'(1);
    else                trunc_o = '0;
  end
endmodule

// File: rtl/vbt_len_clamp.sv
module vbt_len_clamp #(
  parameter int MAX_VL = 8,
  parameter int VL_W   = 4
) (
  input  logic [VL_W-1:0] vl_i,
  input  logic [VL_W-1:0] mvl_i,
  output logic [VL_W-1:0] len_o
);
  localparam logic [VL_W-1:0] HW_MAX = VL_W'(MAX_VL);
  logic [VL_W-1:0] lim;

  always_comb begin
    lim   = (mvl_i > HW_MAX) ? HW_MAX : mvl_i;
    len_o = (vl_i > lim) ? lim : vl_i;
  end
endmodule

// File: rtl/vbr_trunc_unit.sv
module vbr_trunc_unit
  import vbt_pkg::*;
#(
  parameter int MAX_VL = 8,
  parameter int CTR_W  = 16,
  localparam int VL_W  = $clog2(MAX_VL + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MAX_VL-1:0] cond_i,
  input  logic [MAX_VL-1:0] pred_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic [VL_W-1:0]   mvl_i,
  input  logic [CTR_W-1:0]  ctr_i,
  input  logic              vlset_i,
  input  logic              vsb_i,
  input  logic              vli_i,
  input  logic              sz_i,
  input  logic              ctr_test_i,
  input  logic              cti_i,
  input  logic              link_i,
  output logic [VL_W-1:0]   vl_o,
  output logic [CTR_W-1:0]  ctr_o,
  output logic              taken_o,
  output logic              lr_we_o,
  output logic              done_o
);
  vbt_state_e        state_q;
  vbt_mode_t         mode_q;
  logic [MAX_VL-1:0] cond_q, pred_q;
  logic [VL_W-1:0]   len_q, idx_q, last_q, vl_q;
  logic              last_v_q, taken_q, done_q;
  logic [CTR_W-1:0]  ctr_q;

  logic [VL_W-1:0]   len_in, trunc;
  logic              active, succ, hit, dec, at_end, len_zero;

  vbt_len_clamp #(.MAX_VL(MAX_VL), .VL_W(VL_W)) u_clamp (
    .vl_i(vl_i), .mvl_i(mvl_i), .len_o(len_in)
  );

  // element under test always sits in bit 0 (vectors shift right)
  vbt_elem_eval u_eval (
    .cond_bit_i(cond_q[0]), .pred_bit_i(pred_q[0]), .mode_i(mode_q),
    .active_o(active), .succ_o(succ), .hit_o(hit), .dec_o(dec)
  );

  vbt_len_calc #(.VL_W(VL_W)) u_calc (
    .idx_i(idx_q), .last_idx_i(last_q), .last_v_i(last_v_q),
    .vli_i(mode_q.vli), .sz_i(mode_q.sz), .trunc_o(trunc)
  );

  assign len_zero = (len_q == '0);
  assign at_end   = (idx_q == len_q - VL_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      mode_q   <= '0;
      cond_q   <= '0;
      pred_q   <= '0;
      len_q    <= '0;
      idx_q    <= '0;
      last_q   <= '0;
      last_v_q <= 1'b0;
      vl_q     <= '0;
      ctr_q    <= '0;
      taken_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q  <= ST_RUN;
            mode_q   <= '{vlset: vlset_i, vsb: vsb_i, vli: vli_i, sz: sz_i,
                          ctr_test: ctr_test_i, cti: cti_i, link: link_i};
            cond_q   <= cond_i;
            pred_q   <= pred_i;
            len_q    <= len_in;
            idx_q    <= '0;
            last_q   <= '0;
            last_v_q <= 1'b0;
            ctr_q    <= ctr_i;
            taken_q  <= 1'b0;
          end
        end
        ST_RUN: begin
          if (len_zero) begin
            vl_q    <= '0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (hit && !mode_q.vli) begin
            // exclusive: stop before any counter or branch effect
            vl_q    <= trunc;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            if (active) begin
              ctr_q    <= ctr_q - CTR_W'(dec);
              taken_q  <= succ;
              last_q   <= idx_q;
              last_v_q <= 1'b1;
            end
            if (hit) begin
              vl_q    <= trunc;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else if (at_end) begin
              vl_q    <= len_q;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              idx_q  <= idx_q + VL_W'(1);
              cond_q <= cond_q >> 1;
              pred_q <= pred_q >> 1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign vl_o    = vl_q;
  assign ctr_o   = ctr_q;
  assign taken_o = taken_q;
  assign done_o  = done_q;
  assign lr_we_o = done_q & taken_q & mode_q.link;

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_lr_needs_taken_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lr_we_o |-> (taken_o && done_o));

  p_vl_within_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (vl_o <= len_q));

  p_ctr_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |=>
      (ctr_q == $past(ctr_q) || ctr_q == ($past(ctr_q) - CTR_W'(1))));

  p_masked_keep_ctr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !pred_q[0]) |=> (ctr_q == $past(ctr_q)));

  p_start_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && start_i) |=> (len_q == $past(len_q)));
endmodule

// File: tb/sim_vbr_trunc_unit.sv
module sim_vbr_trunc_unit;
  localparam int MAX_VL = 4;
  localparam int CTR_W  = 8;
  localparam int VL_W   = $clog2(MAX_VL + 1);
  localparam time CLK_PERIOD = 10ns;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [MAX_VL-1:0] cond = '0, pred = '0;
  logic [VL_W-1:0]   vl = '0, mvl = '0;
  logic [CTR_W-1:0]  ctr = '0;
  logic vlset = 0, vsb = 0, vli = 0, sz = 0, ctt = 0, cti = 0, lnk = 0;
  logic [VL_W-1:0]   vl_o;
  logic [CTR_W-1:0]  ctr_o;
  logic              taken_o, lr_we_o, done_o;

  int checks = 0, failures = 0, cycles = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vbr_trunc_unit #(.MAX_VL(MAX_VL), .CTR_W(CTR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cond_i(cond), .pred_i(pred),
    .vl_i(vl), .mvl_i(mvl), .ctr_i(ctr), .vlset_i(vlset), .vsb_i(vsb),
    .vli_i(vli), .sz_i(sz), .ctr_test_i(ctt), .cti_i(cti), .link_i(lnk),
    .vl_o(vl_o), .ctr_o(ctr_o), .taken_o(taken_o), .lr_we_o(lr_we_o), .done_o(done_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      summary();
    end
  end

  task automatic run_op(input logic [MAX_VL-1:0] c, input logic [MAX_VL-1:0] p,
                        input int vlv, input int mvlv, input logic [CTR_W-1:0] cv,
                        input logic m_set, input logic m_vsb, input logic m_vli,
                        input logic m_sz, input logic m_ct, input logic m_cti,
                        input logic m_lk, input logic poke);
    int len, term, last, n, e_vl;
    logic [CTR_W-1:0] e_ctr;
    logic e_tk;
    len = vlv;
    if (mvlv < len) len = mvlv;
    if (MAX_VL < len) len = MAX_VL;
    e_vl = len; e_ctr = cv; e_tk = 1'b0; last = -1;
    term = (len == 0) ? 0 : len - 1;
    for (int i = 0; i < len; i++) begin
      if (p[i]) begin
        if (m_set && (c[i] == m_vsb) && !m_vli) begin
          e_vl = m_sz ? i : last + 1;   // R4 / R5 / R6
          term = i;
          break;
        end
        if (m_ct && (c[i] ^ m_cti)) e_ctr = e_ctr - 1'b1;
        e_tk = c[i];
        if (m_set && (c[i] == m_vsb)) begin
          e_vl = i + 1;                 // R3
          term = i;
          break;
        end
        last = i;
      end
    end

    @(negedge clk);
    cond = c; pred = p; vl = VL_W'(vlv); mvl = VL_W'(mvlv); ctr = cv;
    vlset = m_set; vsb = m_vsb; vli = m_vli; sz = m_sz; ctt = m_ct; cti = m_cti; lnk = m_lk;
    start = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      n++;
      if (poke && n == 1) begin
        start = 1'b1; cond = ~c; pred = ~p; vl = VL_W'(MAX_VL); mvl = VL_W'(MAX_VL);
      end
    end while (!done_o && n < 20);
    start = 1'b0;
    chk("R1 latency", n, term + 2);
    chk("R2/R3/R4/R5/R7 vl", int'(vl_o), e_vl);
    chk("R8/R9/R6 ctr", int'(ctr_o), int'(e_ctr));
    chk("R10 taken", int'(taken_o), int'(e_tk));
    chk("R10 lr_we", int'(lr_we_o), int'(m_lk & e_tk));
    @(negedge clk);
    chk("R11 done pulse", int'(done_o), 0);
    chk("R11 vl hold", int'(vl_o), e_vl);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    chk("R12 reset vl", int'(vl_o), 0);
    chk("R12 reset ctr", int'(ctr_o), 0);
    chk("R12 reset taken", int'(taken_o), 0);
    chk("R12 reset lr_we", int'(lr_we_o), 0);
    chk("R12 reset done", int'(done_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2..R6, R8, R9, R10: all condition/mask patterns under each truncation mode
    for (int md = 0; md < 8; md++)
      for (int c = 0; c < 16; c++)
        for (int p = 0; p < 16; p++)
          run_op(4'(c), 4'(p), MAX_VL, MAX_VL, 8'd9, 1'b1, md[0], md[1], md[2],
                 1'b1, c[0] ^ p[3], p[1], (c == p));

    // R7: length clamp and truncation disabled
    for (int v = 0; v < 8; v++)
      for (int m = 0; m < 8; m++)
        run_op(4'b1010, 4'b1111, v, m, 8'd3, 1'b0, 1'b1, 1'b0, 1'b0,
               m[0], 1'b0, 1'b1, 1'b0);

    // R8: counter wraps, and stays when counter-test is off
    run_op(4'b1111, 4'b1111, 4, 4, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    run_op(4'b0110, 4'b1111, 4, 4, 8'd77, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R4/R5/R3: masked-skip example, hit at element 3 after element 1 passed
    run_op(4'b0010, 4'b1010, 4, 4, 8'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R4 skip example", int'(vl_o), 2);
    run_op(4'b0010, 4'b1010, 4, 4, 8'd5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R5 skip example", int'(vl_o), 3);
    run_op(4'b0010, 4'b1010, 4, 4, 8'd5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R3 skip example", int'(vl_o), 4);

    summary();
  end
endmodule